// File: doc/BRIEF.md
# Ternary Byte-Pair Codec

This block turns pairs of bytes into a stream of base-3 digits for a ternary high-rate link, and turns such a stream back into bytes. On the transmit side, each accepted byte pair gets one even-parity bit per byte. The resulting 18-bit group is cut into six 3-bit slices. Each slice is a number from 0 to 7, and the block writes it as two ternary digits (trits), most significant first. The trits leave one per handshake on a valid/ready stream, each coded on two wires of a bus. At the nominal 25 Mtrit/s symbol rate this carries 33.3 Mbit/s of payload.

The receive side takes trits one per valid cycle and rebuilds the slices and then the bytes. It checks both parity bits and flags any trit pair that cannot come from a 3-bit slice. A line driver that maps trits onto wire transitions sits downstream of the transmit stream, and upstream of the receive input. Command words and CRC framing belong to other logic.

The byte width is a parameter. It must be chosen so that two bytes plus two parity bits divide evenly into 3-bit slices (the default of 8 gives 18 bits).

Top module: `trit_pair_codec`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `rx_done` is 0.
- R2: The transmitted 18-bit group is, from its most significant bit down: byte A (bit 7 first), byte B (bit 7 first), the parity of A, then the parity of B. Each parity bit is the XOR of its byte's bits, so byte plus parity holds an even count of ones.
- R3: The group is sent as six 3-bit slices, starting at bits 17..15 and ending at bits 2..0. Each slice is read with its highest bit as the most significant.
- R4: A slice of value v is sent as two trits, first v/3 (integer division) and then v mod 3. Trit codes are 2'b00 for 0, 2'b01 for 1 and 2'b10 for 2. The code 2'b11 never appears while `out_valid` is 1.
- R5: One accepted pair yields exactly twelve trit handshakes, after which `out_valid` drops. `in_ready` stays 0 from acceptance until the twelfth trit has been taken, so `in_valid` and the input bytes have no effect during that time. It returns to 1 in the cycle after the twelfth trit.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_trit` hold their values into the next cycle.
- R7: After twelve trits on the receive side, `rx_done` is 1 for exactly one cycle, in the cycle after the twelfth trit is taken. `rx_byte_a` and `rx_byte_b` then carry the bytes rebuilt by the inverse of R2 to R4. Cycles with `rx_valid` at 0 are skipped and do not count.
- R8: `rx_sym_err` is 1 with `rx_done` when any trit pair of that group gives 3*first+second above 7, or when any received code is 2'b11.
- R9: `rx_par_err[0]` is 1 with `rx_done` when the received parity bit for byte A differs from the XOR of the rebuilt byte A. `rx_par_err[1]` does the same for byte B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte pair offered |
| in_ready | output | 1 | Encoder idle, pair will be taken |
| in_byte_a | input | BYTE_W | First byte of the pair |
| in_byte_b | input | BYTE_W | Second byte of the pair |
| out_valid | output | 1 | Trit on `out_trit` is valid |
| out_ready | input | 1 | Downstream takes the trit |
| out_trit | output | 2 | Trit code (00, 01, 10) |
| rx_valid | input | 1 | Received trit present |
| rx_trit | input | 2 | Received trit code |
| rx_done | output | 1 | One-cycle pulse: a pair is rebuilt |
| rx_byte_a | output | BYTE_W | Rebuilt first byte |
| rx_byte_b | output | BYTE_W | Rebuilt second byte |
| rx_sym_err | output | 1 | Illegal trit pair or code in the group |
| rx_par_err | output | 2 | Parity mismatch, bit 0 byte A, bit 1 byte B |

## Verification
The transmitter can only produce legal groups, so the receiver's error paths are hard to reach. The two that matter most are a trit pair worth 8 and a group whose own parity is wrong. The bench reaches them by building its own trit sequences. It encodes frames whose parity bit is flipped on purpose, and it splices the pair (2,2) or the code 2'b11 into an otherwise clean group. On the transmit side, the hard case is a new pair offered while the current one is still going out. The bench keeps `in_valid` high with different bytes through a whole stretched transmission, and it drops the request only in the cycle that takes the last trit.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ILLEGAL = 2'b11;

  // 3-bit slice -> {first trit, second trit}
  function automatic logic [3:0] split_triplet(input logic [2:0] v);
    trit_t hi;
    trit_t lo;
    hi = (v >= 3'd6) ? 2'd2 : ((v >= 3'd3) ? 2'd1 : 2'd0);
    lo = 2'(v - 3'(hi) * 3'd3);
    return {hi, lo};
  endfunction

  // {bad, value} from two received trit codes
  function automatic logic [4:0] join_trits(input trit_t hi, input trit_t lo);
    logic [3:0] v;
    logic       bad;
    v   = 4'(hi) * 4'd3 + 4'(lo);
    bad = (hi == TRIT_ILLEGAL) || (lo == TRIT_ILLEGAL) || (v > 4'd7);
    return {bad, v};
  endfunction

endpackage

// File: rtl/tpc_parity_gen.sv
module tpc_parity_gen #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [LANES*BYTE_W-1:0] data,
  output logic [LANES-1:0]        par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = ^data[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/tpc_enc.sv
module tpc_enc
  import tpc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] byte_a,
  input  logic [BYTE_W-1:0] byte_b,
  output logic              out_valid,
  input  logic              out_ready,
  output trit_t             out_trit
);
  localparam int FRAME_W   = 2 * (BYTE_W + 1);
  localparam int NUM_SLICE = FRAME_W / 3;
  localparam int NUM_TRITS = 2 * NUM_SLICE;
  localparam int IDX_W     = $clog2(NUM_TRITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TRITS - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;
  trit_t              trit_q;
  logic [1:0]         par;
  logic [FRAME_W-1:0] new_frame;

  tpc_parity_gen #(.BYTE_W(BYTE_W), .LANES(2)) par_i (
    .data ({byte_b, byte_a}),
    .par  (par)
  );

  assign new_frame = {byte_a, byte_b, par[0], par[1]};

  function automatic trit_t trit_at(input logic [FRAME_W-1:0] f,
                                    input logic [IDX_W-1:0]   idx);
    int unsigned s;
    logic [2:0]  slice;
    logic [3:0]  pair;
    s     = 32'(idx) >> 1;
    slice = 3'(f >> (FRAME_W - 3 * (s + 1)));
    pair  = split_triplet(slice);
    return idx[0] ? pair[1:0] : pair[3:2];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      trit_q  <= '0;
    end else if (!busy_q) begin
      if (in_valid) begin
        frame_q <= new_frame;
        idx_q   <= '0;
        busy_q  <= 1'b1;
        trit_q  <= trit_at(new_frame, '0);
      end
    end else if (out_ready) begin
      if (idx_q == LAST_IDX) begin
        idx_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        trit_q <= trit_at(frame_q, idx_q + 1'b1);
      end
    end
  end

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign out_trit  = trit_q;
endmodule

// File: rtl/tpc_dec.sv
module tpc_dec
  import tpc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  trit_t             rx_trit,
  output logic              done,
  output logic [BYTE_W-1:0] byte_a,
  output logic [BYTE_W-1:0] byte_b,
  output logic              sym_err,
  output logic [1:0]        par_err
);
  localparam int FRAME_W   = 2 * (BYTE_W + 1);
  localparam int NUM_SLICE = FRAME_W / 3;
  localparam int NUM_TRITS = 2 * NUM_SLICE;
  localparam int IDX_W     = $clog2(NUM_TRITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TRITS - 1);

  logic [IDX_W-1:0]   phase_q;
  trit_t              hi_q;
  logic [FRAME_W-1:0] acc_q;
  logic               err_q;
  logic [4:0]         joined;
  logic [FRAME_W-1:0] acc_next;
  logic [BYTE_W-1:0]  nxt_a;
  logic [BYTE_W-1:0]  nxt_b;
  logic [1:0]         calc_par;

  assign joined   = join_trits(hi_q, rx_trit);
  assign acc_next = {acc_q[FRAME_W-4:0], joined[2:0]};
  assign nxt_a    = acc_next[FRAME_W-1 -: BYTE_W];
  assign nxt_b    = acc_next[FRAME_W-1-BYTE_W -: BYTE_W];

  tpc_parity_gen #(.BYTE_W(BYTE_W), .LANES(2)) chk_par_i (
    .data ({nxt_b, nxt_a}),
    .par  (calc_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      hi_q    <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
      done    <= 1'b0;
      byte_a  <= '0;
      byte_b  <= '0;
      sym_err <= 1'b0;
      par_err <= '0;
    end else begin
      done <= 1'b0;
      if (rx_valid) begin
        if (!phase_q[0]) begin
          hi_q  <= rx_trit;
          err_q <= err_q | (rx_trit == TRIT_ILLEGAL);
        end else begin
          acc_q <= acc_next;
        end
        if (phase_q == LAST_IDX) begin
          phase_q <= '0;
          err_q   <= 1'b0;
          done    <= 1'b1;
          byte_a  <= nxt_a;
          byte_b  <= nxt_b;
          sym_err <= err_q | joined[4];
          par_err <= calc_par ^ {acc_next[0], acc_next[1]};
        end else begin
          phase_q <= phase_q + 1'b1;
          if (phase_q[0]) err_q <= err_q | joined[4];
        end
      end
    end
  end
endmodule

// File: rtl/trit_pair_codec.sv
module trit_pair_codec
  import tpc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte_a,
  input  logic [BYTE_W-1:0] in_byte_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_trit,
  input  logic              rx_valid,
  input  logic [1:0]        rx_trit,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte_a,
  output logic [BYTE_W-1:0] rx_byte_b,
  output logic              rx_sym_err,
  output logic [1:0]        rx_par_err
);
  tpc_enc #(.BYTE_W(BYTE_W)) enc_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .byte_a    (in_byte_a),
    .byte_b    (in_byte_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_trit  (out_trit)
  );

  tpc_dec #(.BYTE_W(BYTE_W)) dec_i (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_trit  (rx_trit),
    .done     (rx_done),
    .byte_a   (rx_byte_a),
    .byte_b   (rx_byte_b),
    .sym_err  (rx_sym_err),
    .par_err  (rx_par_err)
  );
endmodule

// File: rtl/trit_pair_codec_chk.sv
module trit_pair_codec_chk #(
  parameter int BYTE_W = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_trit,
  input logic       rx_done
);
  localparam int NUM_TRITS = 2 * ((2 * (BYTE_W + 1)) / 3);
  localparam int CNT_W     = $clog2(NUM_TRITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_TRITS - 1);

  logic [CNT_W-1:0] sent_cnt;

  always_ff @(posedge clk) begin
    if (rst) sent_cnt <= '0;
    else if (out_valid && out_ready)
      sent_cnt <= (sent_cnt == CNT_LAST) ? '0 : sent_cnt + 1'b1;
  end

  a_r4_code_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_trit != 2'b11));

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_trit)));

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r5_start_clean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && sent_cnt == '0));

  a_r5_twelve_then_idle: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && sent_cnt == CNT_LAST) |=> (!out_valid && in_ready));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
endmodule

bind trit_pair_codec trit_pair_codec_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_trit  (out_trit),
  .rx_done   (rx_done)
);

// File: tb/trit_pair_codec_tb_top.sv
module trit_pair_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte_a = '0;
  logic [7:0] in_byte_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [1:0] out_trit;
  logic       rx_valid = 1'b0;
  logic [1:0] rx_trit = '0;
  logic       rx_done;
  logic [7:0] rx_byte_a;
  logic [7:0] rx_byte_b;
  logic       rx_sym_err;
  logic [1:0] rx_par_err;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  trit_pair_codec #(.BYTE_W(8)) dut_i (.*);

  localparam logic [15:0] VEC [6] = '{16'h0000, 16'hFFFF, 16'hA55A,
                                      16'h0180, 16'h7E81, 16'h3C07};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2 group layout: A, B, parity A, parity B
  function automatic logic [17:0] model_frame(input logic [7:0] a, input logic [7:0] b);
    return {a, b, ^a, ^b};
  endfunction

  // R3/R4: six slices high first, each as v/3 then v%3
  function automatic logic [23:0] model_trits(input logic [17:0] f);
    logic [23:0] t;
    for (int k = 0; k < 6; k++) begin
      int v;
      v = int'(f[17-3*k -: 3]);
      t[23-4*k -: 2] = 2'(v / 3);
      t[21-4*k -: 2] = 2'(v % 3);
    end
    return t;
  endfunction

  task automatic encode(input logic [7:0] a, input logic [7:0] b,
                        input bit keep_req, output logic [23:0] got);
    int   n;
    bit   held_v;
    logic [1:0] held_t;
    n = 0; held_v = 0; held_t = '0; got = '0;
    @(negedge clk);
    in_byte_a = a; in_byte_b = b; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && !in_ready, "R5", "taken pair starts stream",
          {out_valid, in_ready}, 2'b10);
    if (keep_req) begin
      in_byte_a = ~a; in_byte_b = b ^ 8'h5A;
    end else in_valid = 1'b0;
    for (int cyc = 0; cyc < 100 && n < 12; cyc++) begin
      bit rdy;
      rdy = (cyc % 3) != 2;
      if (held_v) begin
        check(out_valid && out_trit == held_t, "R6", "stalled trit held",
              {out_valid, out_trit}, {1'b1, held_t});
        held_v = 0;
      end
      if (out_valid && in_ready)
        check(0, "R5", "in_ready during stream", 1, 0);
      out_ready = rdy;
      if (out_valid && rdy) begin
        got[23-2*n -: 2] = out_trit;
        n++;
        if (n == 12) in_valid = 1'b0;
      end else if (out_valid) begin
        held_v = 1; held_t = out_trit;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(n == 12 && !out_valid && in_ready, "R5", "twelve trits then idle",
          {n, out_valid, in_ready}, {32'd12, 2'b01});
  endtask

  task automatic rx_send(input logic [23:0] t, input bit gap);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (gap && k == 5) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1;
      rx_trit  = t[23-2*k -: 2];
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [23:0] got;
    logic [23:0] exp;
    logic [17:0] f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(in_ready && !out_valid && !rx_done, "R1", "reset outputs",
          {in_ready, out_valid, rx_done}, 3'b100);

    // Table walk: R2 R3 R4 on transmit, R7 round trip
    foreach (VEC[i]) begin
      f   = model_frame(VEC[i][15:8], VEC[i][7:0]);
      exp = model_trits(f);
      encode(VEC[i][15:8], VEC[i][7:0], 1'b0, got);
      check(got == exp, "R2 R3 R4", "trit sequence", got, exp);
      rx_send(got, i == 2);
      check(rx_done && rx_byte_a == VEC[i][15:8] && rx_byte_b == VEC[i][7:0],
            "R7", "rebuilt pair", {rx_done, rx_byte_a, rx_byte_b}, {1'b1, VEC[i]});
      check(!rx_sym_err && rx_par_err == 2'b00, "R8 R9", "clean group flags",
            {rx_sym_err, rx_par_err}, 0);
      @(negedge clk);
      check(!rx_done, "R7", "done is one cycle", rx_done, 0);
    end

    // R5: request held high with other bytes during the stream is ignored
    exp = model_trits(model_frame(8'hC3, 8'h12));
    encode(8'hC3, 8'h12, 1'b1, got);
    check(got == exp, "R5", "busy-time request ignored", got, exp);

    // R9: parity of byte A wrong
    f = model_frame(8'h6B, 8'h90); f[1] = ~f[1];
    rx_send(model_trits(f), 1'b0);
    check(rx_done && rx_par_err == 2'b01 && !rx_sym_err, "R9", "parity A flip",
          {rx_done, rx_sym_err, rx_par_err}, 4'b1001);
    // R9: parity of byte B wrong
    f = model_frame(8'h6B, 8'h90); f[0] = ~f[0];
    rx_send(model_trits(f), 1'b0);
    check(rx_done && rx_par_err == 2'b10 && !rx_sym_err, "R9", "parity B flip",
          {rx_done, rx_sym_err, rx_par_err}, 4'b1010);

    // R8: pair (2,2) = 8 in slice 3
    exp = model_trits(model_frame(8'h00, 8'h00));
    exp[15:12] = 4'b1010;
    rx_send(exp, 1'b0);
    check(rx_done && rx_sym_err, "R8", "pair worth 8", {rx_done, rx_sym_err}, 2'b11);
    // R8: code 2'b11 as second trit of slice 4
    exp = model_trits(model_frame(8'h00, 8'h00));
    exp[9:8] = 2'b11;
    rx_send(exp, 1'b0);
    check(rx_done && rx_sym_err, "R8", "illegal code", {rx_done, rx_sym_err}, 2'b11);
    // R8: error does not leak into the next clean group
    exp = model_trits(model_frame(8'h55, 8'hAA));
    rx_send(exp, 1'b0);
    check(rx_done && !rx_sym_err && rx_byte_a == 8'h55, "R8", "flag cleared next group",
          {rx_done, rx_sym_err, rx_byte_a}, {2'b10, 8'h55});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule